// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a vector of level-sensitive interrupt request lines and turns them into one interrupt line toward a processor. Each request line passes through a two-flop synchronizer and then lands in a pending image that mirrors the line's level. Software never latches or clears that image. A software-written enable mask is ANDed with the pending image. If any enabled line is active, the registered interrupt output goes high.

Software reaches the block over a simple 32-bit register bus with a single-cycle registered response. Only two offsets return data: the enable mask and the pending image. Two control offsets take writes and discard them. All other accesses read as zero and raise a one-cycle error strobe. Software finds the source by reading the pending image, and it stops an active line by clearing its enable bit or by removing the request at the source.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask reads 0, the pending image matches the synchronized inputs (0 while the inputs are low), and `irq_out` and `bus_err` are 0.
- R2: Bit i of the pending image (read at offset 0x0C) follows `irq_req[i]` through a two-flop synchronizer. The image sets while the line is high and clears when it goes low. A level change is first returned by a read whose bus cycle is sampled on the third rising edge after the change.
- R3: Offset 0x04 holds the enable mask. A write stores all 32 bits of `bus_wdata`, and a read returns the stored value. Bit i set to 1 enables request line i.
- R4: `irq_out` is 1 exactly when the bitwise AND of the enable mask and the pending image is non-zero.
- R5: `irq_out` is registered. A change on `irq_req` reaches `irq_out` on the third rising edge after it. A mask write takes effect on `irq_out` one edge after the edge that stores the write.
- R6: Writes to offsets 0x00 and 0x14 are accepted without an error strobe and change neither the mask nor `irq_out`.
- R7: A read of any offset other than 0x04 and 0x0C returns 0 and pulses `bus_err` for one cycle.
- R8: A write to any offset other than 0x00, 0x04 and 0x14 changes no state and pulses `bus_err` for one cycle.
- R9: The pending image cannot be written. A write to 0x0C leaves it unchanged and is flagged like any other unmapped write.
- R10: Only word-aligned full accesses are decoded. An address with either of its two low bits set is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Level-sensitive request lines, may be asynchronous |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read, 0 otherwise |
| bus_err | output | 1 | One-cycle strobe for an unmapped access |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
Read data and the error strobe are due one edge after the edge that samples the access. The bench drives each access on a falling edge and captures both outputs on the next falling edge. A request edge needs three rising edges to reach `irq_out`: two synchronizer flops and the output register. The bench samples `irq_out` after two edges, where it must still hold the old value, and again after three, where it must hold the new value. A mask write takes two edges, so the bench checks `irq_out` right after the write and again one cycle later. The pending-read test checks the same synchronizer depth by reading immediately after a level change, where the read must return the old value, and then reading once more.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Offsets whose byte position software relies on.
  localparam int unsigned OFF_CTRL_A = 32'h00;
  localparam int unsigned OFF_ENABLE = 32'h04;
  localparam int unsigned OFF_LEVELS = 32'h0C;
  localparam int unsigned OFF_CTRL_B = 32'h14;

  typedef enum logic [2:0] {
    ACC_ENABLE,
    ACC_LEVELS,
    ACC_DISCARD,
    ACC_UNMAPPED
  } acc_kind_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("irqc_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output acc_kind_e         kind
);

  localparam logic [ADDR_W-1:0] A_CTRL_A = ADDR_W'(OFF_CTRL_A);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_LEVELS = ADDR_W'(OFF_LEVELS);
  localparam logic [ADDR_W-1:0] A_CTRL_B = ADDR_W'(OFF_CTRL_B);

  always_comb begin
    kind = ACC_UNMAPPED;
    if (addr[1:0] == 2'b00) begin
      if (addr == A_ENABLE) begin
        kind = ACC_ENABLE;
      end else if (addr == A_LEVELS) begin
        // Pending image is read-only: a write here is unmapped.
        kind = we ? ACC_UNMAPPED : ACC_LEVELS;
      end else if ((addr == A_CTRL_A) || (addr == A_CTRL_B)) begin
        // Control offsets only swallow writes; reads are unmapped.
        kind = we ? ACC_DISCARD : ACC_UNMAPPED;
      end
    end
  end

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               we,
  input  acc_kind_e          kind,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_IRQ-1:0] levels,
  output logic [NUM_IRQ-1:0] enable_q,
  output logic [DATA_W-1:0]  rdata_q,
  output logic               err_q
);

  generate
    if (NUM_IRQ > DATA_W) begin : g_bad_width
      initial $error("irqc_regfile: more request lines than data bits");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      rdata_q <= '0;
      err_q   <= sel && (kind == ACC_UNMAPPED);
      if (sel) begin
        unique case (kind)
          ACC_ENABLE: begin
            if (we) enable_q <= wdata[NUM_IRQ-1:0];
            else    rdata_q  <= DATA_W'(enable_q);
          end
          ACC_LEVELS:   rdata_q <= DATA_W'(levels);
          ACC_DISCARD:  ;
          ACC_UNMAPPED: ;
          default:      ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqc_combine.sv
module irqc_combine #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] enable,
  input  logic [NUM_IRQ-1:0] levels,
  output logic               irq_q
);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(enable & levels);
  end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               irq_out
);

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] mask_q;
  acc_kind_e          acc_kind;

  irqc_sync #(
    .WIDTH (NUM_IRQ),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (irq_req),
    .dout(pend_q)
  );

  irqc_decode #(
    .ADDR_W(ADDR_W)
  ) u_decode (
    .addr(bus_addr),
    .we  (bus_we),
    .kind(acc_kind)
  );

  irqc_regfile #(
    .NUM_IRQ(NUM_IRQ),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .we      (bus_we),
    .kind    (acc_kind),
    .wdata   (bus_wdata),
    .levels  (pend_q),
    .enable_q(mask_q),
    .rdata_q (bus_rdata),
    .err_q   (bus_err)
  );

  irqc_combine #(
    .NUM_IRQ(NUM_IRQ)
  ) u_comb (
    .clk   (clk),
    .rst   (rst),
    .enable(mask_q),
    .levels(pend_q),
    .irq_q (irq_out)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_err,
  input logic               irq_out,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic [NUM_IRQ-1:0] pend_q
);

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic rd_mapped, wr_mask;
  assign rd_mapped = (bus_addr == ADDR_W'(32'h04)) || (bus_addr == ADDR_W'(32'h0C));
  assign wr_mask   = bus_sel && bus_we && (bus_addr == ADDR_W'(32'h04));

  // R2: pending image is the input two edges back
  p_pend_sync_r2: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (pend_q == $past(irq_req, 2)));

  // R3: mask write stores the data
  p_mask_store_r3: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (mask_q == $past(bus_wdata[NUM_IRQ-1:0])));

  // R4/R5: output is the registered OR of enabled pending bits
  p_irq_combine_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == |($past(mask_q & pend_q))));

  // R6/R8: mask changes only on a mask write
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));

  // R7: unmapped read returns zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && !rd_mapped) |=> (bus_rdata == '0));

  // R7/R8: error strobe only follows an access
  p_err_after_access_r8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));

endmodule

bind lvl_irq_ctrl irqc_checker #(
  .NUM_IRQ(NUM_IRQ),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_req  (irq_req),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .bus_err  (bus_err),
  .irq_out  (irq_out),
  .mask_q   (mask_q),
  .pend_q   (pend_q)
);

// File: tb/sim_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lvl_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lvl_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    e = bus_err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 bus_err", {31'b0, bus_err}, 32'h0);
    rd(8'h04, d, e); chk("R1 mask", d, 32'h0);
    rd(8'h0C, d, e); chk("R1 pending", d, 32'h0);
  endtask

  task automatic t_pending_follow;
    logic [31:0] d; logic e;
    irq_req = 32'hA5A5_0F0F; idle(4);
    rd(8'h0C, d, e); chk("R2 pending image", d, 32'hA5A5_0F0F);
    chk("R2 no err", {31'b0, e}, 32'h0);
    irq_req = 32'h0000_8001;           // change at a falling edge
    rd(8'h0C, d, e); chk("R2 sync depth old", d, 32'hA5A5_0F0F);
    rd(8'h0C, d, e); chk("R2 sync depth new", d, 32'h0000_8001);
    irq_req = '0; idle(4);
    rd(8'h0C, d, e); chk("R2 clears when low", d, 32'h0);
  endtask

  task automatic t_mask_rw;
    logic [31:0] d; logic e;
    wr(8'h04, 32'hDEAD_BEEF, e); chk("R3 write no err", {31'b0, e}, 32'h0);
    rd(8'h04, d, e); chk("R3 mask readback", d, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0, e);
    rd(8'h04, d, e); chk("R3 mask cleared", d, 32'h0);
  endtask

  task automatic t_combine;
    logic e;
    wr(8'h04, 32'h0000_0100, e);
    irq_req = 32'h0000_0100; idle(4);
    chk("R4 enabled line", {31'b0, irq_out}, 32'h1);
    irq_req = 32'h0000_0200; idle(4);
    chk("R4 disabled line", {31'b0, irq_out}, 32'h0);
    wr(8'h04, 32'h0, e);
    irq_req = 32'hFFFF_FFFF; idle(4);
    chk("R4 mask zero", {31'b0, irq_out}, 32'h0);
    wr(8'h04, 32'h8000_0000, e); idle(2);
    chk("R4 top bit", {31'b0, irq_out}, 32'h1);
    wr(8'h04, 32'h0, e);
    irq_req = '0; idle(4);
  endtask

  task automatic t_latency;
    logic e;
    wr(8'h04, 32'h0000_0008, e); idle(3);
    @(negedge clk); irq_req = 32'h0000_0008;
    idle(2); chk("R5 rise after 2 edges", {31'b0, irq_out}, 32'h0);
    idle(1); chk("R5 rise after 3 edges", {31'b0, irq_out}, 32'h1);
    irq_req = '0;
    idle(2); chk("R5 fall after 2 edges", {31'b0, irq_out}, 32'h1);
    idle(1); chk("R5 fall after 3 edges", {31'b0, irq_out}, 32'h0);
    wr(8'h04, 32'h0, e);
    irq_req = 32'h0000_0008; idle(4);
    wr(8'h04, 32'h0000_0008, e);
    chk("R5 mask write edge", {31'b0, irq_out}, 32'h0);
    idle(1); chk("R5 mask write plus one", {31'b0, irq_out}, 32'h1);
  endtask

  task automatic t_discard_writes;
    logic [31:0] d; logic e;
    // mask = 0x8, irq_req bit3 high, irq_out high from previous test
    wr(8'h00, 32'h0, e); chk("R6 offset 0x00 no err", {31'b0, e}, 32'h0);
    wr(8'h14, 32'h0, e); chk("R6 offset 0x14 no err", {31'b0, e}, 32'h0);
    idle(1); chk("R6 irq_out kept", {31'b0, irq_out}, 32'h1);
    rd(8'h04, d, e); chk("R6 mask kept", d, 32'h0000_0008);
  endtask

  task automatic t_unmapped_read;
    logic [31:0] d; logic e;
    rd(8'h08, d, e); chk("R7 read 0x08 data", d, 32'h0); chk("R7 read 0x08 err", {31'b0, e}, 32'h1);
    idle(1); chk("R7 err one cycle", {31'b0, bus_err}, 32'h0);
    rd(8'h00, d, e); chk("R7 read 0x00 data", d, 32'h0); chk("R7 read 0x00 err", {31'b0, e}, 32'h1);
    rd(8'hF0, d, e); chk("R7 read 0xF0 data", d, 32'h0);
  endtask

  task automatic t_unmapped_write;
    logic [31:0] d; logic e;
    wr(8'h08, 32'hFFFF_FFFF, e); chk("R8 write err", {31'b0, e}, 32'h1);
    idle(1); chk("R8 err one cycle", {31'b0, bus_err}, 32'h0);
    wr(8'h40, 32'h0, e);
    rd(8'h04, d, e); chk("R8 mask unchanged", d, 32'h0000_0008);
  endtask

  task automatic t_pending_readonly;
    logic [31:0] d; logic e;
    wr(8'h0C, 32'h0, e); chk("R9 write flagged", {31'b0, e}, 32'h1);
    rd(8'h0C, d, e); chk("R9 pending unchanged", d, 32'h0000_0008);
    chk("R9 irq_out unchanged", {31'b0, irq_out}, 32'h1);
  endtask

  task automatic t_misaligned;
    logic [31:0] d; logic e;
    rd(8'h05, d, e); chk("R10 misaligned read data", d, 32'h0);
    chk("R10 misaligned read err", {31'b0, e}, 32'h1);
    wr(8'h06, 32'h0, e); chk("R10 misaligned write err", {31'b0, e}, 32'h1);
    rd(8'h04, d, e); chk("R10 mask unchanged", d, 32'h0000_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pending_follow();
    t_mask_rw();
    t_combine();
    t_latency();
    t_discard_writes();
    t_unmapped_read();
    t_unmapped_write();
    t_pending_readonly();
    t_misaligned();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule